// File: doc/BRIEF.md
# Supply Supervisor Sequencer

This block turns three comparator flags about the supply rail into a graded response for a processor subsystem. The flags say whether the rail is above a warning level, above the minimum operating level and above the battery switchover level. Each flag is first synchronised to the processor clock. It then has to hold a new value for a set number of cycles before the sequencer acts on it.

The block has three responses, from mildest to most severe. A sag below the warning level raises an early-warning interrupt request with a fixed vector, and the processor keeps running. A sag below the minimum operating level holds the processor in reset and drives every decoded memory chip enable and the read/write strobe to their inactive high level. A sag below the switchover level also selects the battery as the power source.

When the rail comes back above the minimum level, the strobes are released, but the processor reset is held for a long fixed delay counted in clocks. An external active-high reset pin can force the processor reset at any time.

The sequencer has five states: NORMAL, WARN, RESET_LOW, BATTERY and POR_DELAY. The transitions on a falling supply are:
- NORMAL to WARN when the warning flag drops.
- NORMAL or WARN to RESET_LOW when the minimum flag drops.
- Any state to BATTERY when the switchover flag drops.
- POR_DELAY to RESET_LOW when the minimum flag drops during the delay.

The transitions on a rising supply are:
- BATTERY to RESET_LOW when only the switchover flag is back.
- BATTERY or RESET_LOW to POR_DELAY when the minimum flag is back.
- POR_DELAY to NORMAL when the delay expires with the warning flag high.
- POR_DELAY to WARN when the delay expires with the warning flag low.
- WARN to NORMAL when the warning flag returns.

The block leaves its own asynchronous reset in BATTERY.

Top module: `pwr_supervisor`

## Requirements
- R1: A NORMAL to WARN transition, taken while `warn_en` is 1, sets `irq_req`. `irq_vector` always reads 8'h2B. The processor reset stays low and the strobes keep passing through.
- R2: `irq_req` stays set until `irq_ack` is high on a clock edge, and then clears on the next edge. It is set once for each falling crossing. No request is raised if `warn_en` was 0 at the crossing, or if WARN is entered from POR_DELAY.
- R3: In RESET_LOW (supply between the switchover and minimum levels), `cpu_reset` is 1, every bit of `ce_n_out` is 1 and `rw_n_out` is 1. In NORMAL, WARN and POR_DELAY, `ce_n_out` follows `ce_n_in` and `rw_n_out` follows `rw_n_in`.
- R4: In BATTERY (switchover flag low), `batt_sel` is 1, `cpu_reset` is 1 and the strobes are inactive. The block's own reset leaves it in BATTERY with `irq_req` at 0.
- R5: On entry to POR_DELAY the strobes are released, and `cpu_reset` stays 1 for exactly POR_CYCLES clocks (default 21504) before it falls.
- R6: `rst_pin` at 1 forces `cpu_reset` to 1 within four clocks, without forcing the strobes. Releasing the pin drops `cpu_reset` within four clocks, with no power-on delay.
- R7: A flag change that lasts fewer than HYST_CYCLES raw clocks has no effect. A change that lasts exactly HYST_CYCLES clocks is taken.
- R8: Any clock on which `cpu_reset` is 1 clears a pending `irq_req`, and this takes priority over setting it.
- R9: When only the switchover flag returns, the block goes from BATTERY to RESET_LOW: `batt_sel` falls and `cpu_reset` and the strobe forcing stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| rst_pin | input | 1 | External reset request, active high, asynchronous |
| above_warn | input | 1 | Raw comparator: supply above the warning level |
| above_min | input | 1 | Raw comparator: supply above the minimum operating level |
| above_batt | input | 1 | Raw comparator: supply above the battery switchover level |
| warn_en | input | 1 | Enables the early-warning interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |
| ce_n_in | input | CE_W | Decoded memory chip enables from the memory controller, active low |
| rw_n_in | input | 1 | Read/write strobe from the memory controller |
| irq_req | output | 1 | Pending early-warning interrupt request |
| irq_vector | output | 8 | Interrupt vector address, fixed at 8'h2B |
| cpu_reset | output | 1 | Processor reset, active high |
| ce_n_out | output | CE_W | Gated chip enables to memory |
| rw_n_out | output | 1 | Gated read/write strobe to memory |
| batt_sel | output | 1 | Selects the battery as the power source |

## Verification
The random phase moves the supply between the warning band and full supply, with `warn_en` and acknowledge pulses drawn at random. This separates falling crossings from rising ones, enabled requests from masked ones, and one request per crossing from requests that are sticky or raised again. Directed steps walk the supply down to the switchover band, back up through RESET_LOW, and into POR_DELAY from both BATTERY and RESET_LOW. The clocks with the strobes released and the reset still held are counted, which shows an exact delay apart from one that is off by a cycle and shows strobe release apart from reset release. Comparator glitches one cycle shorter than the filter window and exactly as long as it check the hysteresis boundary, and reset-pin pulses show the pin path apart from the supply path.

// File: rtl/pwr_sup_pkg.sv
`timescale 1ns/1ps
package pwr_sup_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL    = 3'd0,
        ST_WARN      = 3'd1,
        ST_RESET_LOW = 3'd2,
        ST_BATTERY   = 3'd3,
        ST_POR_DELAY = 3'd4
    } pwr_state_e;

    localparam logic [7:0] WARN_VECTOR = 8'h2B;

    localparam int FLAG_BATT = 0;
    localparam int FLAG_MIN  = 1;
    localparam int FLAG_WARN = 2;
    localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/flag_filter.sv
`timescale 1ns/1ps
module flag_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   HYST_CYCLES = 4,
    parameter logic RESET_VAL   = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic raw_in,
    output logic filt_out
);
    localparam int CNT_W = (HYST_CYCLES > 1) ? $clog2(HYST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HYST_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_cnt;
    logic                   filt_q;
    logic                   differs;

    // synchroniser chain, one flop per stage
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) sync_q[0] <= RESET_VAL;
                    else         sync_q[0] <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) sync_q[g] <= RESET_VAL;
                    else         sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign differs = (sync_q[SYNC_STAGES-1] != filt_q);

    // the output flips on the HYST_CYCLES-th consecutive differing cycle
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            run_cnt <= '0;
            filt_q  <= RESET_VAL;
        end else if (!differs) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            run_cnt <= '0;
            filt_q  <= sync_q[SYNC_STAGES-1];
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign filt_out = filt_q;

endmodule

// File: rtl/por_timer.sv
`timescale 1ns/1ps
module por_timer #(
    parameter int POR_CYCLES = 21504
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(POR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)      cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (!done)   cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == CNT_LAST);

endmodule

// File: rtl/supply_fsm.sv
`timescale 1ns/1ps
module supply_fsm
    import pwr_sup_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       f_batt,
    input  logic       f_min,
    input  logic       f_warn,
    input  logic       por_done,
    input  logic       ext_rst,
    input  logic       warn_en,
    input  logic       irq_ack,
    output pwr_state_e state_o,
    output logic       por_run,
    output logic       cpu_reset,
    output logic       strobe_kill,
    output logic       batt_sel,
    output logic       irq_req
);
    pwr_state_e state_q, state_d;
    logic       supply_reset;
    logic       irq_q;
    logic       warn_event;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (!f_batt)      state_d = ST_BATTERY;
                else if (!f_min)  state_d = ST_RESET_LOW;
                else if (!f_warn) state_d = ST_WARN;
            end
            ST_WARN: begin
                if (!f_batt)      state_d = ST_BATTERY;
                else if (!f_min)  state_d = ST_RESET_LOW;
                else if (f_warn)  state_d = ST_NORMAL;
            end
            ST_RESET_LOW: begin
                if (!f_batt)      state_d = ST_BATTERY;
                else if (f_min)   state_d = ST_POR_DELAY;
            end
            ST_BATTERY: begin
                if (f_batt && f_min) state_d = ST_POR_DELAY;
                else if (f_batt)     state_d = ST_RESET_LOW;
            end
            ST_POR_DELAY: begin
                if (!f_batt)       state_d = ST_BATTERY;
                else if (!f_min)   state_d = ST_RESET_LOW;
                else if (por_done) state_d = f_warn ? ST_NORMAL : ST_WARN;
            end
            default: state_d = ST_BATTERY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_BATTERY;
        else         state_q <= state_d;
    end

    // outputs decoded from the current state
    always_comb begin
        supply_reset = 1'b0;
        strobe_kill  = 1'b0;
        batt_sel     = 1'b0;
        por_run      = 1'b0;
        unique case (state_q)
            ST_NORMAL, ST_WARN: ;
            ST_RESET_LOW: begin
                supply_reset = 1'b1;
                strobe_kill  = 1'b1;
            end
            ST_BATTERY: begin
                supply_reset = 1'b1;
                strobe_kill  = 1'b1;
                batt_sel     = 1'b1;
            end
            ST_POR_DELAY: begin
                supply_reset = 1'b1;
                por_run      = 1'b1;
            end
            default: begin
                supply_reset = 1'b1;
                strobe_kill  = 1'b1;
            end
        endcase
    end

    assign cpu_reset  = supply_reset | ext_rst;
    assign warn_event = (state_q == ST_NORMAL) && (state_d == ST_WARN) && warn_en;

    // pending request: reset clears, then a fresh crossing, then acknowledge
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)         irq_q <= 1'b0;
        else if (cpu_reset)  irq_q <= 1'b0;
        else if (warn_event) irq_q <= 1'b1;
        else if (irq_ack)    irq_q <= 1'b0;
    end

    assign irq_req = irq_q;
    assign state_o = state_q;

endmodule

// File: rtl/pwr_supervisor.sv
`timescale 1ns/1ps
module pwr_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HYST_CYCLES = 4,
    parameter int POR_CYCLES  = 21504,
    parameter int CE_W        = 4
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            rst_pin,
    input  logic            above_warn,
    input  logic            above_min,
    input  logic            above_batt,
    input  logic            warn_en,
    input  logic            irq_ack,
    input  logic [CE_W-1:0] ce_n_in,
    input  logic            rw_n_in,
    output logic            irq_req,
    output logic [7:0]      irq_vector,
    output logic            cpu_reset,
    output logic [CE_W-1:0] ce_n_out,
    output logic            rw_n_out,
    output logic            batt_sel
);
    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] f_flags;
    logic                 ext_rst;
    logic                 por_run;
    logic                 por_done;
    logic                 strobe_kill;
    pwr_state_e           cur_state;

    assign raw_flags[FLAG_BATT] = above_batt;
    assign raw_flags[FLAG_MIN]  = above_min;
    assign raw_flags[FLAG_WARN] = above_warn;

    genvar i;
    generate
        for (i = 0; i < NUM_FLAGS; i++) begin : g_flag
            flag_filter #(
                .SYNC_STAGES (SYNC_STAGES),
                .HYST_CYCLES (HYST_CYCLES),
                .RESET_VAL   (1'b0)
            ) u_filt (
                .clk      (clk),
                .arst_n   (arst_n),
                .raw_in   (raw_flags[i]),
                .filt_out (f_flags[i])
            );
        end
    endgenerate

    // reset pin: synchronised only, no extra hold-off
    flag_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .HYST_CYCLES (1),
        .RESET_VAL   (1'b0)
    ) u_rst_sync (
        .clk      (clk),
        .arst_n   (arst_n),
        .raw_in   (rst_pin),
        .filt_out (ext_rst)
    );

    por_timer #(
        .POR_CYCLES (POR_CYCLES)
    ) u_por (
        .clk    (clk),
        .arst_n (arst_n),
        .run    (por_run),
        .done   (por_done)
    );

    supply_fsm u_fsm (
        .clk         (clk),
        .arst_n      (arst_n),
        .f_batt      (f_flags[FLAG_BATT]),
        .f_min       (f_flags[FLAG_MIN]),
        .f_warn      (f_flags[FLAG_WARN]),
        .por_done    (por_done),
        .ext_rst     (ext_rst),
        .warn_en     (warn_en),
        .irq_ack     (irq_ack),
        .state_o     (cur_state),
        .por_run     (por_run),
        .cpu_reset   (cpu_reset),
        .strobe_kill (strobe_kill),
        .batt_sel    (batt_sel),
        .irq_req     (irq_req)
    );

    assign ce_n_out   = strobe_kill ? {CE_W{1'b1}} : ce_n_in;
    assign rw_n_out   = strobe_kill ? 1'b1 : rw_n_in;
    assign irq_vector = WARN_VECTOR;

endmodule

// File: rtl/pwr_supervisor_chk.sv
`timescale 1ns/1ps
module pwr_supervisor_chk #(
    parameter int POR_CYCLES = 21504,
    parameter int CE_W       = 4
) (
    input logic            clk,
    input logic            arst_n,
    input logic            warn_en,
    input logic            irq_req,
    input logic            cpu_reset,
    input logic            batt_sel,
    input logic [CE_W-1:0] ce_n_out,
    input logic            rw_n_out,
    input logic            por_state
);
    localparam int LEN_W = $clog2(POR_CYCLES + 1);

    logic [LEN_W-1:0] por_len;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)        por_len <= '0;
        else if (!por_state) por_len <= '0;
        else                por_len <= por_len + 1'b1;
    end

    // R4: battery selection implies processor reset
    p_batt_reset_r4: assert property (@(posedge clk) disable iff (!arst_n)
        batt_sel |-> cpu_reset);

    // R3: strobes inactive whenever the battery is selected
    p_batt_strobes_r3: assert property (@(posedge clk) disable iff (!arst_n)
        batt_sel |-> (rw_n_out && (&ce_n_out)));

    // R1: a new request only appears when the warning was enabled
    p_irq_enabled_r1: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(irq_req) |-> $past(warn_en));

    // R8: reset clears any pending request on the following edge
    p_irq_cleared_r8: assert property (@(posedge clk) disable iff (!arst_n)
        $past(cpu_reset) |-> !irq_req);

    // R5: leaving the delay into running state takes exactly POR_CYCLES clocks
    p_por_len_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (!por_state && $past(por_state) && !cpu_reset)
            |-> ($past(por_len) == LEN_W'(POR_CYCLES - 1)));

endmodule

bind pwr_supervisor pwr_supervisor_chk #(
    .POR_CYCLES (POR_CYCLES),
    .CE_W       (CE_W)
) u_chk (
    .clk       (clk),
    .arst_n    (arst_n),
    .warn_en   (warn_en),
    .irq_req   (irq_req),
    .cpu_reset (cpu_reset),
    .batt_sel  (batt_sel),
    .ce_n_out  (ce_n_out),
    .rw_n_out  (rw_n_out),
    .por_state (cur_state == pwr_sup_pkg::ST_POR_DELAY)
);

// File: tb/sim_pwr_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_supervisor;

    localparam int HYST   = 4;
    localparam int POR_N  = 21504;
    localparam int CE_W   = 4;
    localparam int SETTLE = HYST + 8;

    logic            clk = 1'b0;
    logic            arst_n = 1'b0;
    logic            rst_pin = 1'b0;
    logic            above_warn = 1'b0;
    logic            above_min = 1'b0;
    logic            above_batt = 1'b0;
    logic            warn_en = 1'b0;
    logic            irq_ack = 1'b0;
    logic [CE_W-1:0] ce_n_in = 4'b0101;
    logic            rw_n_in = 1'b0;
    logic            irq_req;
    logic [7:0]      irq_vector;
    logic            cpu_reset;
    logic [CE_W-1:0] ce_n_out;
    logic            rw_n_out;
    logic            batt_sel;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int cur_level = 0;
    bit exp_irq = 1'b0;

    always #2.5 clk = ~clk;

    pwr_supervisor #(
        .HYST_CYCLES (HYST),
        .POR_CYCLES  (POR_N),
        .CE_W        (CE_W)
    ) u0 (
        .clk        (clk),
        .arst_n     (arst_n),
        .rst_pin    (rst_pin),
        .above_warn (above_warn),
        .above_min  (above_min),
        .above_batt (above_batt),
        .warn_en    (warn_en),
        .irq_ack    (irq_ack),
        .ce_n_in    (ce_n_in),
        .rw_n_in    (rw_n_in),
        .irq_req    (irq_req),
        .irq_vector (irq_vector),
        .cpu_reset  (cpu_reset),
        .ce_n_out   (ce_n_out),
        .rw_n_out   (rw_n_out),
        .batt_sel   (batt_sel)
    );

    function automatic logic [CE_W:0] exp_strobes(input bit forced,
                                                  input logic [CE_W-1:0] ce,
                                                  input logic rw);
        return forced ? {(CE_W+1){1'b1}} : {ce, rw};
    endfunction

    function automatic bit exp_cross_irq(input int from_lvl, input int to_lvl,
                                         input bit en, input bit prior);
        if (from_lvl == 3 && to_lvl == 2 && en) return 1'b1;
        return prior;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_level(input int lvl);
        above_batt = (lvl >= 1);
        above_min  = (lvl >= 2);
        above_warn = (lvl >= 3);
        cur_level  = lvl;
    endtask

    task automatic sample;
        @(negedge clk);
    endtask

    task automatic check_strobes(input bit forced, input string req);
        sample();
        check({ce_n_out, rw_n_out} == exp_strobes(forced, ce_n_in, rw_n_in), req,
              {ce_n_out, rw_n_out}, exp_strobes(forced, ce_n_in, rw_n_in));
    endtask

    task automatic por_measure(input string req);
        int cnt = 0;
        int guard = 0;
        sample();
        while (guard < POR_N + 200 && !(cnt > 0 && !cpu_reset)) begin
            if (cpu_reset && {ce_n_out, rw_n_out} == {ce_n_in, rw_n_in}) cnt++;
            @(negedge clk);
            guard++;
        end
        check(cnt == POR_N, req, cnt, POR_N);
        check(cpu_reset == 1'b0, req, cpu_reset, 0);
        #1;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        cycles(3);
        sample();
        // R4: reset state
        check(batt_sel == 1'b1, "R4 reset batt_sel", batt_sel, 1);
        check(cpu_reset == 1'b1, "R4 reset cpu_reset", cpu_reset, 1);
        check({ce_n_out, rw_n_out} == 5'h1F, "R4 reset strobes", {ce_n_out, rw_n_out}, 5'h1F);
        check(irq_req == 1'b0, "R4 reset irq", irq_req, 0);
        check(irq_vector == 8'h2B, "R1 vector", irq_vector, 8'h2B);
        #1;
        arst_n = 1'b1;
        cycles(2);

        // R5: power-up from BATTERY straight into POR_DELAY
        set_level(3);
        por_measure("R5 power-up delay");

        // R1 R2: random steps between warning band and full supply
        for (int s = 0; s < 40; s++) begin
            int nl;
            bit en;
            nl = ($urandom % 2) ? 3 : 2;
            en = $urandom % 2;
            ce_n_in = CE_W'($urandom);
            rw_n_in = $urandom % 2;
            warn_en = en;
            exp_irq = exp_cross_irq(cur_level, nl, en, exp_irq);
            set_level(nl);
            cycles(SETTLE);
            sample();
            check(irq_req == exp_irq, "R2 random irq", irq_req, exp_irq);
            check(cpu_reset == 1'b0, "R1 runs during warning", cpu_reset, 0);
            check_strobes(1'b0, "R3 strobes pass");
            #1;
            if ($urandom % 3 == 0) begin
                irq_ack = 1'b1;
                cycles(1);
                irq_ack = 1'b0;
                exp_irq = 1'b0;
                cycles(1);
                sample();
                check(irq_req == 1'b0, "R2 ack clears", irq_req, 0);
                #1;
            end
        end

        // prepare NORMAL with nothing pending
        set_level(3);
        cycles(SETTLE);
        irq_ack = 1'b1; cycles(1); irq_ack = 1'b0; cycles(1);

        // R2: masked crossing
        warn_en = 1'b0;
        set_level(2);
        cycles(SETTLE);
        sample();
        check(irq_req == 1'b0, "R2 masked crossing", irq_req, 0);
        #1;
        set_level(3);
        cycles(SETTLE);

        // R7: glitch one shorter than the window is ignored
        warn_en = 1'b1;
        above_warn = 1'b0;
        cycles(HYST - 1);
        above_warn = 1'b1;
        cycles(SETTLE);
        sample();
        check(irq_req == 1'b0, "R7 short glitch ignored", irq_req, 0);
        #1;
        // R7: glitch of exactly the window is taken
        above_warn = 1'b0;
        cycles(HYST);
        above_warn = 1'b1;
        cycles(SETTLE);
        sample();
        check(irq_req == 1'b1, "R7 full-window glitch taken", irq_req, 1);
        #1;
        // R2: stays pending with no acknowledge
        cycles(20);
        sample();
        check(irq_req == 1'b1, "R2 held pending", irq_req, 1);
        #1;

        // R6 R8: reset pin
        rst_pin = 1'b1;
        cycles(4);
        sample();
        check(cpu_reset == 1'b1, "R6 pin forces reset", cpu_reset, 1);
        check_strobes(1'b0, "R6 pin leaves strobes");
        #1;
        rst_pin = 1'b0;
        cycles(4);
        sample();
        check(cpu_reset == 1'b0, "R6 release no delay", cpu_reset, 0);
        check(irq_req == 1'b0, "R8 reset cleared irq", irq_req, 0);
        #1;

        // R3: brown-out below minimum
        warn_en = 1'b1;
        set_level(1);
        cycles(SETTLE);
        sample();
        check(cpu_reset == 1'b1, "R3 brown-out reset", cpu_reset, 1);
        check(batt_sel == 1'b0, "R3 no battery yet", batt_sel, 0);
        check(irq_req == 1'b0, "R2 no irq on deep drop", irq_req, 0);
        check_strobes(1'b1, "R3 strobes forced");
        #1;

        // R4: below switchover
        set_level(0);
        cycles(SETTLE);
        sample();
        check(batt_sel == 1'b1, "R4 battery selected", batt_sel, 1);
        check(cpu_reset == 1'b1, "R4 battery reset", cpu_reset, 1);
        check_strobes(1'b1, "R4 strobes forced");
        #1;

        // R9: only switchover flag returns
        set_level(1);
        cycles(SETTLE);
        sample();
        check(batt_sel == 1'b0, "R9 battery released", batt_sel, 0);
        check(cpu_reset == 1'b1, "R9 reset held", cpu_reset, 1);
        check_strobes(1'b1, "R9 strobes still forced");
        #1;

        // R5 R2: up into the warning band via POR_DELAY ends in WARN, no irq
        set_level(2);
        por_measure("R5 delay from RESET_LOW");
        cycles(SETTLE);
        sample();
        check(irq_req == 1'b0, "R2 no irq entering WARN from delay", irq_req, 0);
        #1;

        // R1: then a real falling crossing raises the request
        set_level(3);
        cycles(SETTLE);
        set_level(2);
        cycles(SETTLE);
        sample();
        check(irq_req == 1'b1, "R1 crossing raises irq", irq_req, 1);
        check(cpu_reset == 1'b0, "R1 execution continues", cpu_reset, 0);
        #1;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule